// File: doc/BRIEF.md
# Flash Quick-Pulse Zeroing Sequencer

This block prepares a byte-wide parallel flash array for bulk erase by driving every byte of an address window to 0x00. It is started with a one-cycle strobe that captures the lowest address, the highest address and the program-pulse length in clock cycles. It then steps from the highest address down to the lowest. For each byte it sends a program-setup command, writes the zero data byte, waits for the pulse time, sends a program-verify command and reads the byte back with output enable asserted. A byte that does not read back as zero gets another pulse. Each byte has a bounded number of pulses.

While it runs, a free-running interval timer is sampled once per program pulse. After every fifth sampled expiry, a one-cycle progress strobe goes out so that a host can keep a slow link alive. When the walk ends, a one-cycle done strobe comes with a 16-bit result code. The code stays valid until the next start.

Top module: `flash_zero_sequencer`

## Requirements
- R1: After reset the block is idle: busy, done and progress are 0, both flash strobes (fl_we_n, fl_oe_n) are high, and status is 0x0000.
- R2: A start pulse while idle captures base_addr, end_addr and pulse_cycles. Busy is high from the next cycle. Later changes on those inputs have no effect on the run.
- R3: Each program pulse writes 0x40 and then 0x00 to the same address. Each write holds fl_we_n low for WE_W cycles. fl_we_n is high for exactly SETUP cycles between the two writes, and fl_oe_n stays high whenever fl_we_n is low.
- R4: After the 0x00 write, fl_we_n stays high for pulse_cycles cycles before the 0xC0 verify write. A captured value of 0 counts as 1.
- R5: SETUP cycles after the 0xC0 write ends, fl_oe_n goes low for RD_WAIT cycles. fl_din is sampled in the last of those cycles, and 0x00 counts as a pass.
- R6: A failed verify repeats the pulse at the same address. The pulse count starts from zero at each new address, so a byte that needs n pulses (n ≤ MAX_RETRY+1) receives exactly n.
- R7: A byte still nonzero after MAX_RETRY+1 (26) pulses ends the run with status 0x0606. No lower address is written.
- R8: Addresses are visited from end_addr down to base_addr and never rise during a run. A run that verifies base_addr ends with status 0x0000.
- R9: The interval timer restarts on start and expires every TICK_CYCLES cycles, latching a single pending flag. Each pulse consumes the flag, and every TICKS_PER_PROG-th consumed expiry raises progress for exactly one cycle.
- R10: A run ends with done high for one cycle, busy low in that same cycle, and status carrying the result. Status holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| base_addr | input | AW | Lowest address to zero |
| end_addr | input | AW | Highest address to zero (first visited) |
| pulse_cycles | input | PW | Program pulse length in clock cycles |
| fl_addr | output | AW | Flash address |
| fl_dout | output | 8 | Command or data byte toward the flash |
| fl_din | input | 8 | Byte read from the flash |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| status | output | 16 | Result: 0x0000 success, 0x0606 programming error |
| progress | output | 1 | One-cycle keep-alive strobe |

## Verification
A behavioural flash model gives each byte its own number of pulses before it reads zero. Random windows with one to three pulses per byte show whether the retry loop and the downward walk work together. Directed windows test the limit: a byte that needs exactly 26 pulses must succeed, and one that needs 27 must abort with no lower address touched. A zero pulse length and a pulse far longer than the timer period show whether the pulse floor and the single latched expiry flag behave. The progress strobes are predicted from the observed command times and compared with the ones the block emits.

// File: rtl/fzq_pkg.sv
package fzq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_CMD_WE,
    ST_CMD_GAP,
    ST_DAT_WE,
    ST_PULSE,
    ST_VFY_WE,
    ST_VFY_GAP,
    ST_READ,
    ST_EVAL
  } fzq_state_e;

  localparam logic [7:0]  CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0]  CMD_PROG_VERIFY = 8'hC0;
  localparam logic [7:0]  DATA_ZERO       = 8'h00;

  localparam logic [15:0] STAT_OK       = 16'h0000;
  localparam logic [15:0] STAT_PROG_ERR = 16'h0606;

endpackage

// File: rtl/fzq_interval.sv
// Keep-alive timer: free-running period counter, one sticky expiry flag,
// and a divider that turns every Nth consumed expiry into a strobe.
module fzq_interval #(
  parameter int unsigned TICK_CYCLES    = 1000000,
  parameter int unsigned TICKS_PER_PROG = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic check,
  output logic progress
);

  localparam int unsigned TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int unsigned XW = (TICKS_PER_PROG > 1) ? $clog2(TICKS_PER_PROG) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TICK_CYCLES - 1);
  localparam logic [XW-1:0] XLAST = XW'(TICKS_PER_PROG - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [XW-1:0] xcnt_q, xcnt_d;
  logic          flag_q, flag_d;
  logic          prog_q, prog_d;
  logic          wrap;

  always_comb begin
    wrap   = run && (tcnt_q == TLAST);
    tcnt_d = tcnt_q;
    xcnt_d = xcnt_q;
    flag_d = flag_q;
    prog_d = 1'b0;
    if (restart) begin
      tcnt_d = '0;
      xcnt_d = '0;
      flag_d = 1'b0;
    end else begin
      if (run) begin
        tcnt_d = wrap ? '0 : tcnt_q + 1'b1;
      end
      if (check && flag_q) begin
        if (xcnt_q == XLAST) begin
          xcnt_d = '0;
          prog_d = 1'b1;
        end else begin
          xcnt_d = xcnt_q + 1'b1;
        end
      end
      flag_d = wrap | (flag_q & ~check);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      xcnt_q <= '0;
      flag_q <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      tcnt_q <= tcnt_d;
      xcnt_q <= xcnt_d;
      flag_q <= flag_d;
      prog_q <= prog_d;
    end
  end

  assign progress = prog_q;

  // R9: the strobe lasts a single cycle
  assert_prog_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    progress |=> !progress);

  // R9: a strobe is only issued when a pending expiry was consumed by a check
  assert_prog_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    progress |-> ($past(flag_q) && $past(check)));

  // R9: the divider never leaves its range
  assert_div_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xcnt_q <= XLAST);

endmodule

// File: rtl/fzq_engine.sv
// Per-byte program / verify loop with a shared down-counter for all timed phases.
module fzq_engine
  import fzq_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned PW        = 16,
  parameter int unsigned WE_W      = 3,
  parameter int unsigned SETUP     = 2,
  parameter int unsigned RD_WAIT   = 3,
  parameter int unsigned MAX_RETRY = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] end_addr,
  input  logic [PW-1:0] pulse_cycles,
  input  logic [7:0]    fl_din,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          busy,
  output logic          done,
  output logic [15:0]   status,
  output logic          check_tick,
  output logic          restart
);

  localparam int unsigned RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
  localparam logic [RW-1:0] RLAST   = RW'(MAX_RETRY);
  localparam logic [PW-1:0] WE_LAST = PW'(WE_W - 1);
  localparam logic [PW-1:0] SU_LAST = PW'(SETUP - 1);
  localparam logic [PW-1:0] RD_LAST = PW'(RD_WAIT - 1);

  fzq_state_e    state_q, state_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pw_q, pw_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] base_q, base_d;
  logic [RW-1:0] pcnt_q, pcnt_d;
  logic [7:0]    rd_q, rd_d;
  logic          done_q, done_d;
  logic [15:0]   status_q, status_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    pw_d     = pw_q;
    addr_d   = addr_q;
    base_d   = base_q;
    pcnt_d   = pcnt_q;
    rd_d     = rd_q;
    done_d   = 1'b0;
    status_d = status_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          addr_d  = end_addr;
          base_d  = base_addr;
          pw_d    = (pulse_cycles == '0) ? PW'(1) : pulse_cycles;
          pcnt_d  = '0;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        cnt_d   = WE_LAST;
        state_d = ST_CMD_WE;
      end
      ST_CMD_WE: begin
        if (cnt_q == '0) begin cnt_d = SU_LAST; state_d = ST_CMD_GAP; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_CMD_GAP: begin
        if (cnt_q == '0) begin cnt_d = WE_LAST; state_d = ST_DAT_WE; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_DAT_WE: begin
        if (cnt_q == '0) begin cnt_d = pw_q - 1'b1; state_d = ST_PULSE; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_PULSE: begin
        if (cnt_q == '0) begin cnt_d = WE_LAST; state_d = ST_VFY_WE; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_VFY_WE: begin
        if (cnt_q == '0) begin cnt_d = SU_LAST; state_d = ST_VFY_GAP; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_VFY_GAP: begin
        if (cnt_q == '0) begin cnt_d = RD_LAST; state_d = ST_READ; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_READ: begin
        if (cnt_q == '0) begin rd_d = fl_din; state_d = ST_EVAL; end
        else cnt_d = cnt_q - 1'b1;
      end
      ST_EVAL: begin
        if (rd_q == DATA_ZERO) begin
          if (addr_q == base_q) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            status_d = STAT_OK;
          end else begin
            addr_d  = addr_q - 1'b1;
            pcnt_d  = '0;
            state_d = ST_CHECK;
          end
        end else if (pcnt_q == RLAST) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          status_d = STAT_PROG_ERR;
        end else begin
          pcnt_d  = pcnt_q + 1'b1;
          state_d = ST_CHECK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      pw_q     <= PW'(1);
      addr_q   <= '0;
      base_q   <= '0;
      pcnt_q   <= '0;
      rd_q     <= '0;
      done_q   <= 1'b0;
      status_q <= STAT_OK;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      pw_q     <= pw_d;
      addr_q   <= addr_d;
      base_q   <= base_d;
      pcnt_q   <= pcnt_d;
      rd_q     <= rd_d;
      done_q   <= done_d;
      status_q <= status_d;
    end
  end

  // Bus strobes decoded straight from the state register.
  always_comb begin
    fl_we_n = !((state_q == ST_CMD_WE) || (state_q == ST_DAT_WE) || (state_q == ST_VFY_WE));
    fl_oe_n = (state_q != ST_READ);
    case (state_q)
      ST_CMD_WE, ST_CMD_GAP:          fl_dout = CMD_PROG_SETUP;
      ST_VFY_WE, ST_VFY_GAP, ST_READ: fl_dout = CMD_PROG_VERIFY;
      default:                        fl_dout = DATA_ZERO;
    endcase
  end

  assign fl_addr    = addr_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign status     = status_q;
  assign check_tick = (state_q == ST_CHECK);
  assign restart    = (state_q == ST_IDLE) && start;

  // R7: the failed-verify count never passes its limit
  assert_retry_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= RLAST);

  // R8: the address never climbs while a run continues
  assert_addr_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (addr_q <= $past(addr_q)));

  // R6: moving to a new address starts its pulse count afresh
  assert_pcnt_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (addr_q != $past(addr_q))) |-> (pcnt_q == '0));

  // R5: output enable opens only after a verify command, never during a write
  assert_oe_after_verify_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> ($past(fl_dout) == CMD_PROG_VERIFY) && fl_we_n);

  // R10: done follows an active run and carries one of the two codes
  assert_done_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy && ((status == STAT_OK) || (status == STAT_PROG_ERR))));

endmodule

// File: rtl/flash_zero_sequencer.sv
module flash_zero_sequencer #(
  parameter int unsigned AW             = 16,
  parameter int unsigned PW             = 16,
  parameter int unsigned WE_W           = 3,
  parameter int unsigned SETUP          = 2,
  parameter int unsigned RD_WAIT        = 3,
  parameter int unsigned MAX_RETRY      = 25,
  parameter int unsigned TICK_CYCLES    = 1000000,
  parameter int unsigned TICKS_PER_PROG = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] end_addr,
  input  logic [PW-1:0] pulse_cycles,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          busy,
  output logic          done,
  output logic [15:0]   status,
  output logic          progress
);

  logic check_tick;
  logic restart;

  fzq_engine #(
    .AW(AW), .PW(PW), .WE_W(WE_W), .SETUP(SETUP),
    .RD_WAIT(RD_WAIT), .MAX_RETRY(MAX_RETRY)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_addr(base_addr), .end_addr(end_addr), .pulse_cycles(pulse_cycles),
    .fl_din(fl_din), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .busy(busy), .done(done), .status(status),
    .check_tick(check_tick), .restart(restart)
  );

  fzq_interval #(
    .TICK_CYCLES(TICK_CYCLES), .TICKS_PER_PROG(TICKS_PER_PROG)
  ) u_interval (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(busy),
    .check(check_tick), .progress(progress)
  );

endmodule

// File: tb/flash_zero_sequencer_test.sv
module flash_zero_sequencer_test;

  localparam int AW = 16, PW = 8, WEW = 2, STP = 1, RDW = 2;
  localparam int MAXR = 25, TICK = 40, NPROG = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [AW-1:0] base_addr, end_addr;
  logic [PW-1:0] pulse_cycles;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dout, fl_din;
  logic fl_we_n, fl_oe_n, busy, done, progress;
  logic [15:0] status;

  always #10 clk = ~clk;  // 50 MHz

  flash_zero_sequencer #(
    .AW(AW), .PW(PW), .WE_W(WEW), .SETUP(STP), .RD_WAIT(RDW),
    .MAX_RETRY(MAXR), .TICK_CYCLES(TICK), .TICKS_PER_PROG(NPROG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_addr(base_addr), .end_addr(end_addr), .pulse_cycles(pulse_cycles),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .busy(busy), .done(done), .status(status), .progress(progress)
  );

  // flash model
  logic [7:0] mem [0:255];
  int need [0:255];
  int pulses [0:255];
  int exp_p [0:255];
  assign fl_din = mem[fl_addr[7:0]];

  int checks = 0, errors = 0;
  int cyc = 0, cyc0 = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  int t_err, s_err, p_err, v_err, o_err, r10_err;
  int we_fall_t, we_rise_t, oe_fall_t, exp_pw, cur_base;
  int x_model, c_prev, exp_prog, obs_prog, done_cnt;
  logic [15:0] done_status;
  logic prev_we, prev_oe;
  logic [7:0] last_cmd;
  logic [AW-1:0] last_cmd_addr, last_setup_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic bit window_has_expiry(input int a, input int c);
    return ((c / TICK) - (a / TICK)) > 0;
  endfunction

  always @(negedge clk) begin
    int rel, gap, c;
    rel = cyc - cyc0;
    if (prev_we && !fl_we_n) begin
      we_fall_t = rel;
      if (!fl_oe_n) t_err++;
      gap = rel - we_rise_t;
      case (fl_dout)
        8'h40: begin
          if (fl_addr > last_setup_addr || int'(fl_addr) < cur_base) o_err++;
          last_setup_addr = fl_addr;
          c = rel - 1;
          if (window_has_expiry(c_prev, c)) begin
            x_model++;
            if (x_model == NPROG) begin exp_prog++; x_model = 0; end
          end
          c_prev = c;
          last_cmd = 8'h40; last_cmd_addr = fl_addr;
        end
        8'h00: begin
          if (last_cmd != 8'h40 || fl_addr != last_cmd_addr || gap != STP) s_err++;
          pulses[fl_addr[7:0]]++;
          if (pulses[fl_addr[7:0]] >= need[fl_addr[7:0]]) mem[fl_addr[7:0]] = 8'h00;
          last_cmd = 8'h00;
        end
        8'hC0: begin
          if (last_cmd != 8'h00 || gap != exp_pw) p_err++;
          last_cmd = 8'hC0;
        end
        default: s_err++;
      endcase
    end
    if (!prev_we && fl_we_n) begin
      if (rel - we_fall_t != WEW) t_err++;
      we_rise_t = rel;
    end
    if (!fl_we_n && !fl_oe_n) t_err++;
    if (prev_oe && !fl_oe_n) begin
      if (rel - we_rise_t != STP || last_cmd != 8'hC0) v_err++;
      oe_fall_t = rel;
    end
    if (!prev_oe && fl_oe_n) begin
      if (rel - oe_fall_t != RDW) v_err++;
    end
    if (progress) obs_prog++;
    if (done) begin
      done_cnt++;
      if (busy) r10_err++;
      done_status = status;
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  task automatic run_case(input int b, input int len, input int pw,
                          input int bad_off, input int bad_need, input string tag);
    bit exp_err;
    int mism, guard;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(($urandom % 255) + 1);
      need[i] = 1 + ($urandom % 3);
      pulses[i] = 0;
      exp_p[i] = 0;
    end
    if (bad_off >= 0) need[(b + bad_off) & 255] = bad_need;
    exp_err = 1'b0;
    for (int a = b + len; a >= b; a--) begin
      if (need[a & 255] > MAXR + 1) begin
        exp_p[a & 255] = MAXR + 1; exp_err = 1'b1; break;
      end
      exp_p[a & 255] = need[a & 255];
    end
    t_err = 0; s_err = 0; p_err = 0; v_err = 0; o_err = 0; r10_err = 0;
    we_fall_t = 0; we_rise_t = 0; oe_fall_t = 0;
    x_model = 0; c_prev = 0; exp_prog = 0; obs_prog = 0; done_cnt = 0;
    prev_we = 1'b1; prev_oe = 1'b1; last_cmd = 8'hFF; last_cmd_addr = '0;
    last_setup_addr = AW'(b + len); cur_base = b;
    exp_pw = (pw == 0) ? 1 : pw;

    @(negedge clk);
    base_addr = AW'(b); end_addr = AW'(b + len); pulse_cycles = PW'(pw);
    start = 1'b1; cyc0 = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
    // R2: scramble the inputs after capture; the run must not notice
    base_addr = AW'(b + 3); end_addr = AW'(b); pulse_cycles = PW'(pw + 5);
    guard = 0;
    while (!done && guard < 30000) begin @(negedge clk); guard++; end
    chk(guard < 30000, "R10", {tag, " watchdog"}, guard, 0);
    repeat (3) @(negedge clk);
    chk(status == done_status, "R10", {tag, " status held"}, status, done_status);
    chk(done_cnt == 1 && r10_err == 0, "R10", {tag, " done single, busy low"}, done_cnt, 1);
    if (exp_err) chk(done_status == 16'h0606, "R7", {tag, " error code"}, done_status, 16'h0606);
    else chk(done_status == 16'h0000, "R8", {tag, " success code"}, done_status, 0);
    mism = 0;
    for (int i = 0; i < 256; i++) if (pulses[i] != exp_p[i]) mism++;
    chk(mism == 0, "R6", {tag, " pulses per byte (R7 stop)"}, mism, 0);
    chk(t_err == 0 && s_err == 0, "R3", {tag, " write timing/order"}, t_err + s_err, 0);
    chk(p_err == 0, "R4", {tag, " pulse length"}, p_err, 0);
    chk(v_err == 0, "R5", {tag, " verify read timing"}, v_err, 0);
    chk(o_err == 0, "R8", {tag, " descending order"}, o_err, 0);
    chk(obs_prog == exp_prog, "R9", {tag, " progress strobes"}, obs_prog, exp_prog);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 global watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0;
    base_addr = '0; end_addr = '0; pulse_cycles = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !progress, "R1", "idle flags", {busy, done, progress}, 0);
    chk(fl_we_n && fl_oe_n, "R1", "strobes high", {fl_we_n, fl_oe_n}, 3);
    chk(status == 16'h0000, "R1", "reset status", status, 0);

    run_case(16'h3A10, 0, 0, -1, 0, "single byte pw0");          // R4 floor
    run_case(16'h3A20, 4, 3, 2, MAXR + 1, "need 26");            // R7 boundary pass
    run_case(16'h3A30, 6, 2, 3, MAXR + 2, "need 27");            // R7 abort
    run_case(16'h3A08, 5, 100, -1, 0, "long pulse");             // R9 single flag
    for (int k = 0; k < 6; k++) begin
      int b, len, pw, bo;
      b   = 16'h3A00 + int'($urandom % 100);
      len = int'($urandom % 31);
      pw  = int'($urandom % 8);
      bo  = (($urandom % 4) == 0) ? int'($urandom % (len + 1)) : -1;
      run_case(b, len, pw, bo, 40, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule